// File: doc/BRIEF.md
# Two-Wire Register Target with Paged Writes and Deferred Commit

This block is a two-wire serial bus target that opens a 256-location byte register space to a bus controller. It sees the clock and data lines already synchronized to its own clock, drives the data line only by pulling it low through an output enable, and answers to a 7-bit address built from a fixed five-bit prefix and two strap pins. A write transfer carries an address byte, then a byte that loads the location counter, then any number of data bytes. A read transfer streams bytes from the location counter until the controller declines one.

Location 00h is special. It holds a volatile wiper setting and a stored initial value that models non-volatile storage. A shadow-enable bit in location 02h decides whether a write to 00h also updates the stored value and which of the two a read of 00h returns. The update of the stored value waits for the STOP that ends the transfer, is dropped if a repeated START ends it instead, and then keeps the target busy for a set number of cycles. During that time the target declines its own address.

Top module: `i2c_page_target`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal 0b01010 followed by the A1 and A0 pins (54h for a write with pins 10, 52h with pins 01). For any other address it does not acknowledge and ignores every byte until the next START, so no register write takes place.
- R2: START is SDA falling while SCL is high and STOP is SDA rising while SCL is high. The output enable is low out of reset, changes only while SCL is low, and is asserted only for an acknowledge bit or a read data bit of value 0.
- R3: The byte after a write address loads the location counter. Each following data byte is written at the counter and acknowledged.
- R4: After each data byte the counter advances only inside its aligned 8-byte page, so a page written with more than eight bytes keeps the last eight that were sent.
- R5: Sequential reads return the byte at the counter and increment it across the full space, wrapping from FFh to 00h, until the controller answers a byte with NACK. After that the target releases the data line.
- R6: With the shadow-enable bit (location 02h, bit 7) at 0, a write to 00h updates the wiper at once and the stored initial value at the next STOP. A read of 00h returns the stored initial value.
- R7: With the shadow-enable bit at 1, a write to 00h changes only the wiper, and a read of 00h returns the wiper.
- R8: When a transfer that wrote 00h ends with a repeated START, the stored initial value does not change and no busy period starts.
- R9: A STOP that commits the stored initial value raises the busy flag for NV_CYCLES clock cycles. While it is high, the target does not acknowledge its address. A STOP with nothing to commit leaves it low.
- R10: Each accepted data byte produces a one-cycle write strobe carrying its location and value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| scl | input | 1 | Synchronized serial clock line |
| sda | input | 1 | Synchronized serial data line as seen on the bus |
| sda_oe | output | 1 | Pull data line low when high |
| addr_pins | input | 2 | Strap pins {A1, A0} forming the low address bits |
| reg_we | output | 1 | One-cycle strobe for each accepted data byte |
| reg_waddr | output | 8 | Location of the strobed byte |
| reg_wdata | output | 8 | Value of the strobed byte |
| wiper | output | 8 | Volatile wiper setting |
| init_val | output | 8 | Stored (non-volatile) initial value |
| shadow_en | output | 1 | Shadow-enable bit |
| nv_busy | output | 1 | Non-volatile commit in progress |

## Verification
The bench builds the target with NV_CYCLES set to 400 and keeps the other defaults, so the full 256-location space and the FFh-to-00h read wrap can be reached. The short busy period lets one run show an address attempt declined right after a commit and then accepted once the window has run out. The strap pins are switched between two settings to show that the matching address follows them.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_MADDR,
    ST_WDATA,
    ST_ACK,
    ST_TX,
    ST_RACK,
    ST_SKIP
  } tgt_state_t;
endpackage

// File: rtl/i2c_line_events.sv
module i2c_line_events (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise  = scl & ~scl_q;
  assign scl_fall  = ~scl & scl_q;
  assign bus_start = scl & scl_q & sda_q & ~sda;
  assign bus_stop  = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
  parameter int          ADDR_W      = 8,
  parameter int          DATA_W      = 8,
  parameter int          WIPER_ADDR  = 0,
  parameter int          SHADOW_ADDR = 2,
  parameter int          SHADOW_BIT  = 7,
  parameter logic [7:0]  IVR_RESET   = 8'h00,
  parameter int          NV_CYCLES   = 50000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  input  logic              nv_commit,
  input  logic              nv_cancel,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] wiper,
  output logic [DATA_W-1:0] init_val,
  output logic              shadow_en,
  output logic              nv_busy
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(NV_CYCLES + 1);

  logic [DATA_W-1:0] mem [0:DEPTH-1];
  logic [DATA_W-1:0] mem_q;
  logic              sel_q;
  logic              pend;
  logic [DATA_W-1:0] pend_val;
  logic [CNT_W-1:0]  nv_cnt;

  // plain array: synchronous write, registered read
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    mem_q <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= 1'b0;
      shadow_en <= 1'b0;
      wiper     <= DATA_W'(IVR_RESET);
      init_val  <= DATA_W'(IVR_RESET);
      pend      <= 1'b0;
      pend_val  <= '0;
      nv_cnt    <= '0;
    end else begin
      sel_q <= (raddr == ADDR_W'(WIPER_ADDR));
      if (nv_cnt != '0) nv_cnt <= nv_cnt - CNT_W'(1);
      if (we && waddr == ADDR_W'(SHADOW_ADDR)) shadow_en <= wdata[SHADOW_BIT];
      if (we && waddr == ADDR_W'(WIPER_ADDR)) begin
        wiper <= wdata;
        if (!shadow_en) begin
          pend     <= 1'b1;
          pend_val <= wdata;
        end
      end
      if (nv_cancel) begin
        pend <= 1'b0;
      end else if (nv_commit && pend) begin
        pend     <= 1'b0;
        init_val <= pend_val;
        nv_cnt   <= CNT_W'(NV_CYCLES);
      end
    end
  end

  assign nv_busy = (nv_cnt != '0);
  assign rdata   = sel_q ? (shadow_en ? wiper : init_val) : mem_q;
endmodule

// File: rtl/i2c_page_target.sv
module i2c_page_target
  import i2c_tgt_pkg::*;
#(
  parameter int         ADDR_W     = 8,
  parameter int         PAGE_BYTES = 8,
  parameter logic [4:0] DEV_PREFIX = 5'b01010,
  parameter int         NV_CYCLES  = 50000,
  parameter logic [7:0] IVR_RESET  = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl,
  input  logic              sda,
  output logic              sda_oe,
  input  logic [1:0]        addr_pins,
  output logic              reg_we,
  output logic [ADDR_W-1:0] reg_waddr,
  output logic [7:0]        reg_wdata,
  output logic [7:0]        wiper,
  output logic [7:0]        init_val,
  output logic              shadow_en,
  output logic              nv_busy
);
  localparam int BYTE_W = 8;
  localparam int BIT_CW = $clog2(BYTE_W);
  localparam int PG_W   = $clog2(PAGE_BYTES);

  logic scl_rise, scl_fall, ev_start, ev_stop;
  tgt_state_t state, after_ack;
  logic [BIT_CW-1:0] cnt;
  logic [BYTE_W-2:0] shreg;
  logic [BYTE_W-2:0] tx;
  logic [BYTE_W-1:0] rx_byte;
  logic [BYTE_W-1:0] rd_data;
  logic [ADDR_W-1:0] ptr;
  logic full, ack_q;

  i2c_line_events u_ev (
    .clk(clk), .rst(rst), .scl(scl), .sda(sda),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(ev_start), .bus_stop(ev_stop)
  );

  i2c_reg_bank #(
    .ADDR_W(ADDR_W), .DATA_W(BYTE_W), .IVR_RESET(IVR_RESET), .NV_CYCLES(NV_CYCLES)
  ) u_bank (
    .clk(clk), .rst(rst), .we(reg_we), .waddr(reg_waddr), .wdata(reg_wdata),
    .raddr(ptr), .nv_commit(ev_stop), .nv_cancel(ev_start),
    .rdata(rd_data), .wiper(wiper), .init_val(init_val),
    .shadow_en(shadow_en), .nv_busy(nv_busy)
  );

  assign rx_byte = {shreg, sda};

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      after_ack <= ST_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      tx        <= '0;
      ptr       <= '0;
      full      <= 1'b0;
      ack_q     <= 1'b0;
      sda_oe    <= 1'b0;
      reg_we    <= 1'b0;
      reg_waddr <= '0;
      reg_wdata <= '0;
    end else begin
      reg_we <= 1'b0;
      if (ev_start) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        full   <= 1'b0;
        sda_oe <= 1'b0;
      end else if (ev_stop) begin
        state  <= ST_IDLE;
        full   <= 1'b0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_MADDR, ST_WDATA: begin
            if (scl_rise) begin
              shreg <= rx_byte[BYTE_W-2:0];
              cnt   <= cnt + BIT_CW'(1);
              if (cnt == BIT_CW'(BYTE_W - 1)) begin
                full <= 1'b1;
                if (state == ST_ADDR) begin
                  ack_q     <= (rx_byte[7:1] == {DEV_PREFIX, addr_pins}) && !nv_busy;
                  after_ack <= rx_byte[0] ? ST_TX : ST_MADDR;
                end else if (state == ST_MADDR) begin
                  ptr       <= rx_byte[ADDR_W-1:0];
                  ack_q     <= 1'b1;
                  after_ack <= ST_WDATA;
                end else begin
                  reg_we    <= 1'b1;
                  reg_waddr <= ptr;
                  reg_wdata <= rx_byte;
                  ptr       <= {ptr[ADDR_W-1:PG_W], ptr[PG_W-1:0] + PG_W'(1)};
                  ack_q     <= 1'b1;
                  after_ack <= ST_WDATA;
                end
              end
            end else if (scl_fall && full) begin
              full <= 1'b0;
              if (ack_q) begin
                sda_oe <= 1'b1;
                state  <= ST_ACK;
              end else begin
                state  <= ST_SKIP;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (after_ack == ST_TX) begin
                tx     <= rd_data[BYTE_W-2:0];
                sda_oe <= ~rd_data[BYTE_W-1];
              end else begin
                sda_oe <= 1'b0;
              end
              state <= after_ack;
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt <= cnt + BIT_CW'(1);
              if (cnt == BIT_CW'(BYTE_W - 1)) begin
                full <= 1'b1;
                ptr  <= ptr + ADDR_W'(1);
              end
            end else if (scl_fall) begin
              if (full) begin
                full   <= 1'b0;
                sda_oe <= 1'b0;
                state  <= ST_RACK;
              end else begin
                sda_oe <= ~tx[BYTE_W-2];
                tx     <= {tx[BYTE_W-3:0], 1'b0};
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              if (!sda) full <= 1'b1;
              else      state <= ST_SKIP;
            end else if (scl_fall && full) begin
              full   <= 1'b0;
              cnt    <= '0;
              tx     <= rd_data[BYTE_W-2:0];
              sda_oe <= ~rd_data[BYTE_W-1];
              state  <= ST_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_page_target_chk.sv
module i2c_page_target_chk (
  input logic       clk,
  input logic       rst,
  input logic       scl,
  input logic       sda_oe,
  input logic       reg_we,
  input logic [7:0] reg_waddr,
  input logic [7:0] reg_wdata,
  input logic [7:0] wiper,
  input logic [7:0] init_val,
  input logic       nv_busy
);
  // R2: the data line is only taken or released while the clock is low
  a_r2_oe_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl);

  // R10: write strobe lasts one cycle
  a_r10_we_single_cycle: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  // R6 / R7: a strobed write to 00h lands in the wiper
  a_r7_wiper_takes_write: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_waddr == 8'h00) |=> (wiper == $past(reg_wdata)));

  // R6 / R9: the stored value only moves when a busy period starts
  a_r9_ivr_moves_with_busy: assert property (@(posedge clk) disable iff (rst)
    !$stable(init_val) |-> $rose(nv_busy));
endmodule

bind i2c_page_target i2c_page_target_chk u_chk (
  .clk(clk), .rst(rst), .scl(scl), .sda_oe(sda_oe),
  .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
  .wiper(wiper), .init_val(init_val), .nv_busy(nv_busy)
);

// File: tb/tb_i2c_page_target.sv
module tb_i2c_page_target;
  localparam int CLK_PERIOD = 10;
  localparam int NV_T = 400;
  localparam logic [7:0] AW = 8'h54;
  localparam logic [7:0] AR = 8'h55;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic [1:0] pins = 2'b10;
  logic sda_oe, reg_we, shadow_en, nv_busy;
  logic [7:0] reg_waddr, reg_wdata, wiper, init_val;
  wire sda_bus = m_sda & ~sda_oe;

  int n_chk = 0;
  int n_fail = 0;
  int we_cnt = 0;
  logic [7:0] we_a, we_d;
  logic [7:0] wbuf [0:15];
  logic [7:0] rbuf [0:15];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_page_target #(.NV_CYCLES(NV_T)) dut (
    .clk(clk), .rst(rst), .scl(scl), .sda(sda_bus), .sda_oe(sda_oe),
    .addr_pins(pins), .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .wiper(wiper), .init_val(init_val), .shadow_en(shadow_en), .nv_busy(nv_busy)
  );

  always @(posedge clk) begin
    if (!rst && reg_we) begin
      we_cnt <= we_cnt + 1;
      we_a   <= reg_waddr;
      we_d   <= reg_wdata;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; wclk(2); scl = 1'b1; wclk(4); scl = 1'b0; wclk(2);
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; wclk(2); scl = 1'b1; wclk(2); b = sda_bus; wclk(2); scl = 1'b0; wclk(2);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wclk(2); scl = 1'b1; wclk(2); m_sda = 1'b0; wclk(2); scl = 1'b0; wclk(2);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wclk(2); scl = 1'b1; wclk(2); m_sda = 1'b1; wclk(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic nb;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(nb);
    ack = ~nb;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) get_bit(b[i]);
    put_bit(~give_ack);
  endtask

  task automatic write_regs(input logic [7:0] a, input int n);
    logic ack;
    bus_start();
    send_byte(AW, ack);  chk("R1 write address ack", ack, 1);
    send_byte(a, ack);   chk("R3 location ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], ack); chk("R3 data ack", ack, 1);
    end
    bus_stop();
  endtask

  task automatic read_regs(input logic [7:0] a, input int n);
    logic ack;
    bus_start();
    send_byte(AW, ack);  chk("R1 write address ack", ack, 1);
    send_byte(a, ack);   chk("R3 location ack", ack, 1);
    bus_start();
    send_byte(AR, ack);  chk("R1 read address ack", ack, 1);
    for (int k = 0; k < n; k++) recv_byte(k != n - 1, rbuf[k]);
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R2 reset oe", sda_oe, 0);
    chk("R6 reset wiper", wiper, 0);
    chk("R6 reset stored value", init_val, 0);
    chk("R9 reset busy", nv_busy, 0);
    chk("R7 reset shadow", shadow_en, 0);
  endtask

  task automatic t_addr_match();
    logic ack;
    int c0;
    bus_start(); send_byte(8'h54, ack); bus_stop();
    chk("R1 match pins 10", ack, 1);
    c0 = we_cnt;
    bus_start(); send_byte(8'h50, ack);
    chk("R1 nack wrong address", ack, 0);
    send_byte(8'h03, ack); chk("R1 ignored byte nack", ack, 0);
    send_byte(8'hAA, ack); chk("R1 ignored byte nack", ack, 0);
    bus_stop();
    chk("R1 no write while ignoring", we_cnt - c0, 0);
    pins = 2'b01; wclk(4);
    bus_start(); send_byte(8'h52, ack); bus_stop();
    chk("R1 match pins 01", ack, 1);
    bus_start(); send_byte(8'h54, ack); bus_stop();
    chk("R1 old address refused", ack, 0);
    pins = 2'b10; wclk(4);
  endtask

  task automatic t_single();
    int c0;
    c0 = we_cnt;
    wbuf[0] = 8'h3C;
    write_regs(8'h05, 1);
    chk("R10 one strobe", we_cnt - c0, 1);
    chk("R10 strobe location", we_a, 8'h05);
    chk("R10 strobe value", we_d, 8'h3C);
    read_regs(8'h05, 1);
    chk("R3 readback", rbuf[0], 8'h3C);
    chk("R9 no busy without commit", nv_busy, 0);
  endtask

  task automatic t_page();
    for (int i = 0; i < 10; i++) wbuf[i] = 8'hA0 + 8'(i);
    write_regs(8'h16, 10);
    read_regs(8'h10, 8);
    for (int j = 0; j < 8; j++) chk("R4 page wrap keeps last eight", rbuf[j], 8'hA2 + 8'(j));
  endtask

  task automatic t_seqread();
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    write_regs(8'hFE, 2);
    read_regs(8'hFE, 3);
    chk("R5 read FE", rbuf[0], 8'h11);
    chk("R5 read FF", rbuf[1], 8'h22);
    chk("R5 wrap to 00", rbuf[2], 8'h00);
    chk("R5 line released after nack", sda_oe, 0);
  endtask

  task automatic t_shadow0();
    logic ack;
    bus_start();
    send_byte(AW, ack); send_byte(8'h00, ack); send_byte(8'h40, ack);
    chk("R6 wiper at once", wiper, 8'h40);
    chk("R6 stored value waits for stop", init_val, 8'h00);
    bus_stop(); wclk(2);
    chk("R6 stored value after stop", init_val, 8'h40);
    chk("R9 busy after commit", nv_busy, 1);
    bus_start(); send_byte(AW, ack); bus_stop();
    chk("R9 address refused while busy", ack, 0);
    wclk(NV_T + 20);
    chk("R9 busy ends", nv_busy, 0);
    read_regs(8'h00, 1);
    chk("R6 read 00 gives stored value", rbuf[0], 8'h40);
  endtask

  task automatic t_rstart_cancel();
    logic ack;
    bus_start();
    send_byte(AW, ack); send_byte(8'h00, ack); send_byte(8'h55, ack);
    bus_start();
    send_byte(AW, ack); send_byte(8'h00, ack);
    bus_start();
    send_byte(AR, ack); chk("R8 read after repeated start ack", ack, 1);
    recv_byte(1'b0, rbuf[0]);
    bus_stop(); wclk(2);
    chk("R8 read 00 keeps old stored value", rbuf[0], 8'h40);
    chk("R8 wiper changed", wiper, 8'h55);
    chk("R8 stored value unchanged", init_val, 8'h40);
    chk("R8 no busy", nv_busy, 0);
  endtask

  task automatic t_shadow1();
    wbuf[0] = 8'h80;
    write_regs(8'h02, 1);
    chk("R7 shadow bit set", shadow_en, 1);
    wbuf[0] = 8'h12;
    write_regs(8'h00, 1); wclk(2);
    chk("R7 wiper written", wiper, 8'h12);
    chk("R7 stored value kept", init_val, 8'h40);
    chk("R7 no busy", nv_busy, 0);
    read_regs(8'h00, 1);
    chk("R7 read 00 gives wiper", rbuf[0], 8'h12);
  endtask

  initial begin
    wclk(5);
    rst = 1'b0;
    wclk(3);
    t_reset();
    t_addr_match();
    t_single();
    t_page();
    t_seqread();
    t_shadow0();
    t_rstart_cancel();
    t_shadow1();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule